// File: doc/BRIEF.md
# Display power-state transition sequencer

This block keeps track of the power state of an attached display panel and moves it between states when asked. A request names a target state and carries a one-cycle start pulse. The block then sends the needed register writes one at a time to a serial link through a command port. Each command carries an address, a byte count and up to two data bytes. The block waits for the link's completion pulse before it sends the next command. Where the panel needs a settling time, the block counts out a one-millisecond pause on its own.

The panel has four states. The block only knows direct sequences between neighbouring states. A longer move is made by chaining those sequences, and a change between the two active resolutions passes through deep standby. The panel's long timing table is played back on every wake into an active state. The table is split into a common part and a part for each resolution, and all three parts are parameters. The reported state changes only when the whole chain has completed without an error.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset the block reports state 0 (deep standby), `busy` and `err` are low and no command is offered. States are encoded 0 = deep standby, 1 = sleep, 2 = full-resolution active, 3 = quarter-resolution active.
- R2: Waking from deep standby to sleep sends command address 0x00 with zero bytes three times. After each of these the block waits exactly `CYC_PER_MS` cycles before offering the next command. It then writes one byte 0x17 to address 0xB0.
- R3: Sleep to an active state writes one byte to 0xBC (0x80 full, 0x81 quarter), one byte to 0x3B (0x00 full, 0x22 quarter), one byte 0x16 to 0xB0 and two bytes 0xFFF9 to 0xB8. It then sends address 0x11 with zero bytes, then the common table entries in order, then the entries of the table for the chosen resolution, and finally address 0x29 with zero bytes.
- R4: Leaving either active state for sleep sends address 0x28 with zero bytes, then two bytes 0x8002 to 0xB8, then address 0x10 with zero bytes.
- R5: Sleep to deep standby writes one byte 0x00 to 0xB0.
- R6: A move between non-neighbouring states chains the sequences through sleep. A move from one active state to the other runs active to sleep, sleep to standby, standby to sleep, then sleep to the new active state. `cur_state` takes the target value in the cycle after the last command completes, and at no other time.
- R7: A start naming the current state sends no command, keeps `busy` low, and clears `err`.
- R8: A command completing with `cmd_err` high ends the chain at once. `cur_state` keeps its old value and `err` rises as `busy` falls. The next accepted start clears `err`.
- R9: `busy` rises in the cycle after an accepted start and stays high until the final command completes. A start while `busy` is high has no effect on the chain or its target. No command is offered while `busy` is low.
- R10: Once offered, a command keeps `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_data` unchanged until the cycle in which `cmd_done` is seen. Only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| tgt_state | input | 2 | Requested state, sampled with `start` |
| cur_state | output | 2 | State the panel is known to be in |
| busy | output | 1 | A chain of commands is in progress |
| err | output | 1 | Last chain ended on a failed command |
| cmd_valid | output | 1 | Command offered to the serial link |
| cmd_addr | output | 8 | Register or command address |
| cmd_len | output | 4 | Number of data bytes following the address (0, 1 or 2) |
| cmd_data | output | 16 | Data; one byte sits in bits 7:0 |
| cmd_done | input | 1 | Link finished the offered command |
| cmd_err | input | 1 | Link reports failure, valid with `cmd_done` |

## Verification
The bench builds the block with `CYC_PER_MS` set to 5, a common table of two entries, a full-resolution table of one entry and a quarter-resolution table of two entries. The short pause lets the exact pause length after each wake command be measured on every wake. The short tables keep the long cross-resolution chain, with its standby detour, to a few hundred cycles. Mixed table lengths also show that each resolution plays back only its own table, and that zero-byte and two-byte entries pass through the table path.

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq #(
  parameter int CYC_PER_MS = 50000,
  parameter int N_COM = 25,
  parameter int N_FUL = 8,
  parameter int N_QTR = 8,
  parameter logic [N_COM*28-1:0] TBL_COM = {
    28'hBA10001, 28'hBB10000, 28'h3A10060, 28'hBF10010, 28'hB110056,
    28'hB210033, 28'hB310011, 28'hB410002, 28'hB51002B, 28'hB610040,
    28'hB710003, 28'hB910004, 28'hBD10004, 28'hBE10000, 28'hC010011,
    28'hC110011, 28'hC210011, 28'hC322040, 28'hC4260C0, 28'hC521020,
    28'hC6260C0, 28'hC725533, 28'hC810000, 28'hC910000, 28'hCA10000},
  parameter logic [N_FUL*28-1:0] TBL_FUL = {
    28'hEC201F0, 28'hCF10002, 28'hD020804, 28'hD110001,
    28'hD220000, 28'hD320D0E, 28'hD4211A4, 28'hD51000E},
  parameter logic [N_QTR*28-1:0] TBL_QTR = {
    28'hED200FF, 28'hD610002, 28'hD720804, 28'hD810001,
    28'hD920008, 28'hDE2050A, 28'hDF20A19, 28'hE01000A}
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  tgt_state,
  output logic [1:0]  cur_state,
  output logic        busy,
  output logic        err,
  output logic        cmd_valid,
  output logic [7:0]  cmd_addr,
  output logic [3:0]  cmd_len,
  output logic [15:0] cmd_data,
  input  logic        cmd_done,
  input  logic        cmd_err
);
  localparam int NMAX = (N_FUL > N_QTR) ? N_FUL : N_QTR;
  localparam int IW = $clog2(N_COM + NMAX + 7);
  localparam int CW = $clog2(CYC_PER_MS + 1);
  localparam logic [1:0] ST_STBY = 2'd0, ST_SLP = 2'd1, ST_FUL = 2'd2, ST_QTR = 2'd3;

  typedef enum logic [2:0] {PH_WAKE, PH_NFUL, PH_NQTR, PH_DOWN, PH_OFF} ph_t;
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_GAP} st_t;

  st_t st;
  ph_t ph;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [1:0] tgt_r, dest;
  logic detour, dly, lst, step_ok;
  logic [27:0] ent;
  int k, nres;

  function automatic ph_t pick(input logic [1:0] p, input logic [1:0] t, input logic d);
    if (p == ST_STBY) return PH_WAKE;
    if (p == ST_SLP) begin
      if (d || t == ST_STBY) return PH_OFF;
      return (t == ST_FUL) ? PH_NFUL : PH_NQTR;
    end
    return PH_DOWN;
  endfunction

  assign k = int'(idx);
  assign nres = (ph == PH_NQTR) ? N_QTR : N_FUL;

  always_comb begin
    ent = '0;
    dly = 1'b0;
    lst = 1'b0;
    dest = ST_SLP;
    case (ph)
      PH_WAKE: begin
        if (k < 3) dly = 1'b1;
        else begin ent = 28'hB010017; lst = 1'b1; end
      end
      PH_NFUL, PH_NQTR: begin
        dest = (ph == PH_NQTR) ? ST_QTR : ST_FUL;
        if (k == 0) ent = (ph == PH_NQTR) ? 28'hBC10081 : 28'hBC10080;
        else if (k == 1) ent = (ph == PH_NQTR) ? 28'h3B10022 : 28'h3B10000;
        else if (k == 2) ent = 28'hB010016;
        else if (k == 3) ent = 28'hB82FFF9;
        else if (k == 4) ent = 28'h1100000;
        else if (k < 5 + N_COM) ent = TBL_COM[(N_COM + 4 - k)*28 +: 28];
        else if (k < 5 + N_COM + nres) begin
          if (ph == PH_NQTR) ent = TBL_QTR[(N_QTR + N_COM + 4 - k)*28 +: 28];
          else               ent = TBL_FUL[(N_FUL + N_COM + 4 - k)*28 +: 28];
        end else begin ent = 28'h2900000; lst = 1'b1; end
      end
      PH_DOWN: begin
        if (k == 0) ent = 28'h2800000;
        else if (k == 1) ent = 28'hB828002;
        else begin ent = 28'h1000000; lst = 1'b1; end
      end
      default: begin
        ent = 28'hB010000;
        lst = 1'b1;
        dest = ST_STBY;
      end
    endcase
  end

  assign step_ok = (st == S_CMD && cmd_done && !cmd_err && !dly) ||
                   (st == S_GAP && cnt == CW'(CYC_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_WAKE; idx <= '0; cnt <= '0;
      cur_state <= ST_STBY; tgt_r <= ST_STBY; detour <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            err <= 1'b0;
            if (tgt_state != cur_state) begin
              tgt_r <= tgt_state;
              detour <= cur_state[1] & tgt_state[1];
              ph <= pick(cur_state, tgt_state, 1'b0);
              idx <= '0;
              st <= S_CMD;
            end
          end
        S_CMD:
          if (cmd_done && cmd_err) begin
            err <= 1'b1;
            st <= S_IDLE;
          end else if (cmd_done && dly) begin
            cnt <= '0;
            st <= S_GAP;
          end
        default:
          if (!step_ok) cnt <= cnt + 1'b1;
      endcase
      if (step_ok) begin
        if (!lst) begin
          idx <= idx + 1'b1;
          st <= S_CMD;
        end else if (dest == tgt_r) begin
          cur_state <= tgt_r;
          st <= S_IDLE;
        end else begin
          if (dest == ST_STBY) detour <= 1'b0;
          ph <= pick(dest, tgt_r, detour && dest != ST_STBY);
          idx <= '0;
          st <= S_CMD;
        end
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_CMD);
  assign cmd_addr  = ent[27:20];
  assign cmd_len   = ent[19:16];
  assign cmd_data  = ent[15:0];

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_data)); // R10
  AST_STATE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_state) |-> $fell(busy) && !err); // R6
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $fell(busy) && $stable(cur_state)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R9
  AST_NOOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && tgt_state == cur_state |=> !busy && !err); // R7
endmodule

// File: tb/disp_pwr_seq_bench.sv
module disp_pwr_seq_bench;
  localparam int CYC = 5;
  localparam int LAT = 2;
  localparam int NC = 2, NF = 1, NQ = 2;
  localparam logic [NC*28-1:0] TC = {28'hA1100AA, 28'hA22BEEF};
  localparam logic [NF*28-1:0] TF = {28'hF010011};
  localparam logic [NQ*28-1:0] TQ = {28'hE110022, 28'hE200000};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] tgt = 2'd0;
  logic [1:0] cur_state;
  logic busy, err, cmd_valid, cmd_done = 1'b0, cmd_err = 1'b0;
  logic [7:0] cmd_addr;
  logic [3:0] cmd_len;
  logic [15:0] cmd_data;

  disp_pwr_seq #(.CYC_PER_MS(CYC), .N_COM(NC), .N_FUL(NF), .N_QTR(NQ),
                 .TBL_COM(TC), .TBL_FUL(TF), .TBL_QTR(TQ)) u_disp_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_state(tgt),
    .cur_state(cur_state), .busy(busy), .err(err), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_err(cmd_err));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  int lat = 0, gap = 0, exp_gap = -1, rn = 0, inj_at = -1;
  logic [27:0] q[$];
  logic [27:0] held;
  logic [1:0] mcur = 2'd0, mtgt = 2'd0;
  logic mbusy = 1'b0, merr = 1'b0;
  string tag = "R1";
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_wake();
    repeat (3) q.push_back(28'h0000000);
    q.push_back(28'hB010017);
  endtask
  task automatic push_norm(input bit quarter);
    q.push_back(quarter ? 28'hBC10081 : 28'hBC10080);
    q.push_back(quarter ? 28'h3B10022 : 28'h3B10000);
    q.push_back(28'hB010016);
    q.push_back(28'hB82FFF9);
    q.push_back(28'h1100000);
    for (int i = 0; i < NC; i++) q.push_back(TC[(NC-1-i)*28 +: 28]);
    if (quarter) for (int i = 0; i < NQ; i++) q.push_back(TQ[(NQ-1-i)*28 +: 28]);
    else         for (int i = 0; i < NF; i++) q.push_back(TF[(NF-1-i)*28 +: 28]);
    q.push_back(28'h2900000);
  endtask
  task automatic push_down();
    q.push_back(28'h2800000);
    q.push_back(28'hB828002);
    q.push_back(28'h1000000);
  endtask
  task automatic push_off();
    q.push_back(28'hB010000);
  endtask

  task automatic build(input logic [1:0] c, input logic [1:0] t);
    case (c)
      2'd0: begin push_wake(); if (t == 2'd2) push_norm(0); if (t == 2'd3) push_norm(1); end
      2'd1: begin if (t == 2'd0) push_off(); if (t == 2'd2) push_norm(0); if (t == 2'd3) push_norm(1); end
      default: begin
        push_down();
        if (t == 2'd0) push_off();
        if (t[1]) begin push_off(); push_wake(); push_norm(t == 2'd3); end
      end
    endcase
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mcur = 2'd0; mbusy = 1'b0; merr = 1'b0;
    end else if (!mbusy && start) begin
      merr = 1'b0;
      if (tgt != mcur) begin mbusy = 1'b1; mtgt = tgt; build(mcur, tgt); end
    end else if (mbusy && cmd_done) begin
      if (cmd_err) begin mbusy = 1'b0; merr = 1'b1; q.delete(); end
      else if (q.size() == 0) begin mbusy = 1'b0; mcur = mtgt; end
    end
  end

  // link responder and per-clock comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_done = 1'b0; cmd_err = 1'b0; lat = 0; gap = 0; exp_gap = -1;
    end else begin
      chk(cur_state == mcur, "R6", "cur_state", cur_state, mcur);
      chk(busy == mbusy, "R9", "busy", busy, mbusy);
      chk(err == merr, "R8", "err", err, merr);
      if (cmd_done) begin
        cmd_done = 1'b0; cmd_err = 1'b0;
      end else if (cmd_valid) begin
        if (lat == 0) begin
          if (exp_gap >= 0) chk(gap == exp_gap, "R2", "pause cycles", gap, exp_gap);
          exp_gap = -1;
          held = {cmd_addr, cmd_len, cmd_data};
        end else
          chk({cmd_addr, cmd_len, cmd_data} == held, "R10", "held command", {cmd_addr, cmd_len, cmd_data}, held);
        if (lat == LAT) begin
          if (q.size() == 0) chk(1'b0, tag, "unexpected command", {cmd_addr, cmd_len, cmd_data}, 0);
          else begin
            logic [27:0] e;
            e = q.pop_front();
            chk({cmd_addr, cmd_len, cmd_data} == e, tag, "command", {cmd_addr, cmd_len, cmd_data}, e);
            rn++;
            cmd_err = (rn == inj_at);
            if (q.size() > 0 && !cmd_err) exp_gap = (e == 28'h0) ? CYC - 1 : 0;
          end
          cmd_done = 1'b1; lat = 0; gap = 0;
        end else lat++;
      end else gap++;
    end
  end

  task automatic pulse(input logic [1:0] t);
    @(negedge clk); start = 1'b1; tgt = t;
    @(negedge clk); start = 1'b0;
  endtask
  task automatic run(input logic [1:0] t, input string r);
    tag = r;
    pulse(t);
    while (mbusy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, r, "commands left unsent", q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cur_state == 2'd0 && !busy && !err && !cmd_valid, "R1", "reset outputs",
        {cur_state, busy, err, cmd_valid}, 0);
    rst_n = 1'b1;
    run(2'd1, "R2");
    chk(cur_state == 2'd1, "R2", "state after wake", cur_state, 1);
    run(2'd2, "R3");
    chk(cur_state == 2'd2, "R3", "state full", cur_state, 2);
    // cross-resolution chain with ignored strobes (R9)
    tag = "R6";
    pulse(2'd3);
    repeat (20) @(negedge clk);
    pulse(2'd0);
    repeat (30) @(negedge clk);
    pulse(2'd1);
    while (mbusy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cur_state == 2'd3, "R9", "target kept despite strobes", cur_state, 3);
    chk(q.size() == 0, "R6", "commands left unsent", q.size(), 0);
    begin
      int n0;
      n0 = rn;
      run(2'd3, "R7");
      chk(rn == n0, "R7", "commands on no-op", rn - n0, 0);
    end
    run(2'd0, "R4");
    chk(cur_state == 2'd0, "R5", "state standby", cur_state, 0);
    run(2'd3, "R6");
    chk(cur_state == 2'd3, "R6", "state quarter", cur_state, 3);
    inj_at = rn + 2;
    run(2'd1, "R8");
    chk(cur_state == 2'd3 && err, "R8", "state/err after failure", {cur_state, err}, {2'd3, 1'b1});
    inj_at = -1;
    run(2'd3, "R7");
    chk(!err, "R7", "err cleared by no-op", err, 0);
    inj_at = rn + 1;
    run(2'd1, "R8");
    inj_at = -1;
    run(2'd1, "R4");
    chk(cur_state == 2'd1 && !err, "R4", "sleep reached", {cur_state, err}, {2'd1, 1'b0});
    run(2'd0, "R5");
    chk(cur_state == 2'd0, "R5", "standby reached", cur_state, 0);
    run(2'd2, "R6");
    run(2'd3, "R6");
    chk(cur_state == 2'd3, "R6", "full to quarter", cur_state, 3);
    run(2'd2, "R6");
    chk(cur_state == 2'd2, "R6", "quarter to full", cur_state, 2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule